// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple synchronous host port and an asynchronous 256K x 8 extended-data-out DRAM. Each host request carries an 18-bit byte address, a read/write flag and a write byte, and is taken on a valid/ready handshake. The controller splits the address into a 9-bit row and a 9-bit column. It sends both over one shared 9-bit address bus and drives the row strobe, column strobe, write enable and output enable as active-low signals. The pad buffers stay outside: the block gives a write byte with its drive enable, and takes the read byte as a separate input.

After a row has been opened it stays open. Later requests to that row are served as single column-strobe cycles at the page rate. A request to another row first closes the current row, waits out the precharge time and then opens the new row. An open row is also closed when a refresh is due or when its row-strobe low time nears the permitted maximum. A free-running timer asks for a column-before-row refresh at a fixed interval, and that refresh wins over host traffic at the next row close. Every analog limit is a whole number of clock cycles, set through a parameter.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the row, column, write and output-enable strobes are all high, `dram_dq_oe` and `rsp_valid` are low and `req_ready` is high.
- R2: The row address is `req_addr[17:9]` and is on `dram_addr` when the row strobe falls. The column address is `req_addr[8:0]` and is on `dram_addr` when the column strobe falls. Bytes written at different rows and columns read back without aliasing.
- R3: A column strobe fall during an access comes at least `T_RCD` cycles after the row strobe fell.
- R4: Before any row-strobe fall, the row strobe has been high for at least `T_PRE` cycles, the larger of `T_RP` and `T_RC - T_RAS_MIN`.
- R5: Every row-strobe low pulse lasts between `T_RAS_MIN` and `T_RAS_MAX` cycles. An idle open row is closed on its own before that maximum.
- R6: A request to the open row causes no row-strobe edge, and back-to-back hits make column strobe falls exactly `T_CASL + T_CASH` cycles apart.
- R7: A request to a row other than the open one makes the row strobe rise (precharge) and then fall once for the new row.
- R8: Each read gives exactly one single-cycle `rsp_valid` pulse, in request order, with the byte stored at that address. The data is sampled after the column strobe has risen and no earlier than `T_RAC` cycles after the row strobe fell.
- R9: During a write, `dram_we_n` is low only while the column strobe is low, `dram_dq_oe` is high with the write byte, `dram_oe_n` is high, and no response is produced.
- R10: A refresh drops the column strobe at least one cycle before the row strobe falls. Refreshes follow one another, and the first follows reset, within `REF_INT` plus a small fixed bound of cycles.
- R11: A pending refresh takes priority over a waiting host request. The request is delayed, not lost, and is served after the refresh.
- R12: `req_ready` is low during a precharge and during a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken this cycle when valid is also high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address, row in [17:9], column in [8:0] |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Byte to drive onto the data pads |
| dram_dq_oe | output | 1 | Pad drive enable for writes |
| dram_dq_in | input | 8 | Byte read from the data pads |

## Verification
The refresh timer can expire in the same cycle that a host request hitting the open row is waiting for ready. This is provoked by running a continuous stream of same-row reads across the instant of the first refresh. The outcome is judged by three things: ready must be low when the refresh begins, the refresh strobe order and interval must hold, and every read in the stream must still return its byte in order, with at least one request seen waiting through the refresh.

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 8,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 5,
  parameter int T_RC      = 12,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 7000,
  parameter int T_RAC     = 6,
  parameter int T_CASL    = 2,
  parameter int T_CASH    = 1,
  parameter int T_CSR     = 1,
  parameter int REF_INT   = 1560
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);

  localparam int ADDR_W  = ROW_W + COL_W;
  localparam int T_PRE   = (T_RP > T_RC - T_RAS_MIN) ? T_RP : T_RC - T_RAS_MIN;
  localparam int T_GUARD = T_CASL + T_CASH + T_RAC + 2;
  localparam int CNT_MAX = T_PRE + T_RAS_MIN + T_RCD + T_CASL + T_CASH + T_CSR;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int RC_W    = $clog2(T_RAS_MAX + 1);
  localparam int PC_W    = $clog2(T_PRE + 1);
  localparam int RT_W    = $clog2(REF_INT);

  localparam logic [CNT_W-1:0] C_RCD  = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] C_CASL = CNT_W'(T_CASL - 1);
  localparam logic [CNT_W-1:0] C_CASH = CNT_W'(T_CASH - 1);
  localparam logic [CNT_W-1:0] C_PRE  = CNT_W'(T_PRE - 1);
  localparam logic [CNT_W-1:0] C_CSR  = CNT_W'(T_CSR - 1);
  localparam logic [CNT_W-1:0] C_RFR  = CNT_W'(T_RAS_MIN - 1);
  localparam logic [RC_W-1:0]  RC_SAT   = RC_W'(T_RAS_MAX);
  localparam logic [RC_W-1:0]  RC_CLOSE = RC_W'(T_RAS_MAX - T_GUARD);
  localparam logic [RC_W-1:0]  RC_MIN1  = RC_W'(T_RAS_MIN - 1);
  localparam logic [RC_W-1:0]  RC_MIN   = RC_W'(T_RAS_MIN);
  localparam logic [RC_W-1:0]  RC_RAC   = RC_W'(T_RAC - 1);
  localparam logic [RC_W-1:0]  RC_RCD   = RC_W'(T_RCD);
  localparam logic [PC_W-1:0]  PC_SAT   = PC_W'(T_PRE);
  localparam logic [RT_W-1:0]  RT_INIT  = RT_W'(REF_INT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_COL, S_CASH, S_OPEN, S_PRE, S_RFC, S_RFR
  } state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic [RC_W-1:0]   ras_cnt;
  logic [PC_W-1:0]   pre_cnt;
  logic [RT_W-1:0]   ref_tmr;
  logic              ref_pend;

  logic hit, at_limit, cnt_zero, cas_end, page_ok, accept, can_close;

  assign hit       = req_addr[ADDR_W-1:COL_W] == row_q;
  assign at_limit  = ras_cnt >= RC_CLOSE;
  assign cnt_zero  = cnt == '0;
  assign cas_end   = (st == S_CASH) && cnt_zero && (we_q || ras_cnt >= RC_RAC);
  assign page_ok   = !ref_pend && !at_limit && hit;
  assign can_close = ras_cnt >= RC_MIN1;
  assign req_ready = ((st == S_IDLE) && !ref_pend) ||
                     (((st == S_OPEN) || cas_end) && page_ok);
  assign accept    = req_valid && req_ready;

  assign dram_ras_n  = !((st == S_ACT) || (st == S_COL) || (st == S_CASH) ||
                         (st == S_OPEN) || (st == S_RFR));
  assign dram_cas_n  = !((st == S_COL) || (st == S_RFC) || (st == S_RFR));
  assign dram_we_n   = !((st == S_COL) && we_q);
  assign dram_oe_n   = !(((st == S_COL) || (st == S_CASH)) && !we_q);
  assign dram_dq_oe  = (st == S_COL) && we_q;
  assign dram_dq_out = wd_q;
  assign dram_addr   = ((st == S_COL) || (st == S_CASH)) ? col_q :
                       (st == S_IDLE) ? req_addr[ADDR_W-1:COL_W] : row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      row_q     <= '0;
      col_q     <= '0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ref_tmr   <= RT_INIT;
      ref_pend  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!cnt_zero) cnt <= cnt - 1'b1;
      if (accept) begin
        col_q <= req_addr[COL_W-1:0];
        we_q  <= req_we;
        wd_q  <= req_wdata;
      end
      case (st)
        S_IDLE:
          if (ref_pend) begin
            st <= S_RFC; cnt <= C_CSR; ref_pend <= 1'b0;
          end else if (accept) begin
            st <= S_ACT; cnt <= C_RCD; row_q <= req_addr[ADDR_W-1:COL_W];
          end
        S_ACT:
          if (cnt_zero) begin st <= S_COL; cnt <= C_CASL; end
        S_COL:
          if (cnt_zero) begin st <= S_CASH; cnt <= C_CASH; end
        S_CASH:
          if (cas_end) begin
            if (!we_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
            if (accept) begin st <= S_COL; cnt <= C_CASL; end
            else st <= S_OPEN;
          end
        S_OPEN:
          if (can_close && (ref_pend || at_limit || (req_valid && !hit))) begin
            st <= S_PRE; cnt <= C_PRE;
          end else if (accept) begin
            st <= S_COL; cnt <= C_CASL;
          end
        S_PRE:
          if (cnt_zero) st <= S_IDLE;
        S_RFC:
          if (cnt_zero) begin st <= S_RFR; cnt <= C_RFR; end
        S_RFR:
          if (cnt_zero) begin st <= S_PRE; cnt <= C_PRE; end
        default: st <= S_IDLE;
      endcase
      if (ref_tmr == '0) begin
        ref_tmr  <= RT_INIT;
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_cnt <= '0;
      pre_cnt <= PC_SAT;
    end else begin
      if (dram_ras_n) ras_cnt <= '0;
      else if (ras_cnt != RC_SAT) ras_cnt <= ras_cnt + 1'b1;
      if (!dram_ras_n) pre_cnt <= '0;
      else if (pre_cnt != PC_SAT) pre_cnt <= pre_cnt + 1'b1;
    end
  end

  p_rcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> (ras_cnt >= RC_RCD));

  p_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (pre_cnt >= PC_SAT));

  p_ras_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (ras_cnt >= RC_MIN));

  p_ras_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (ras_cnt < RC_SAT));

  p_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_OPEN) && accept) |=> (!dram_ras_n && !dram_cas_n));

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_wr_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> (!dram_cas_n && dram_oe_n && dram_dq_oe));

  p_cbr_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((dram_ras_n && !dram_cas_n) || $rose(dram_ras_n)) |-> !req_ready);

endmodule

// File: tb/edo_page_ctrl_test.sv
`timescale 1ns/1ps
module edo_page_ctrl_test;
  localparam int B_RCD    = 2;
  localparam int B_PRE    = 6;
  localparam int B_RASMIN = 6;
  localparam int B_RASMAX = 400;
  localparam int B_PAGE   = 3;
  localparam int B_REFI   = 1560;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [8:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0] dram_dq_out;
  logic [7:0] dq_model = 8'h00;

  always #10 clk = ~clk;

  edo_page_ctrl #(.T_RAS_MAX(B_RASMAX)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_model)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [7:0] mem [int];
  logic [7:0] sh [int];
  int exp_q[$];
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [8:0] m_row = '0;
  int cyc = 0, lo_cnt = 0, hi_cnt = B_PRE;
  int last_cas_fall = -100, cas_gap = 0, last_ref = 0;
  int ras_falls = 0, ras_rises = 0, refreshes = 0, rsp_cnt = 0, max_wait = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!dram_ras_n && prev_ras) begin
        chk(hi_cnt >= B_PRE, "R4 precharge", hi_cnt, B_PRE);
        ras_falls++;
        lo_cnt = 1;
        if (!dram_cas_n) begin
          chk(!prev_cas, "R10 cas first", 0, 1);
          chk(cyc - last_ref <= B_REFI + 24, "R10 interval", cyc - last_ref, B_REFI);
          last_ref = cyc;
          refreshes++;
        end else begin
          m_row = dram_addr;
        end
      end else if (dram_ras_n && !prev_ras) begin
        chk(lo_cnt >= B_RASMIN && lo_cnt <= B_RASMAX, "R5 ras width", lo_cnt, B_RASMIN);
        chk(!req_ready, "R12 ready in precharge", 1, 0);
        ras_rises++;
        hi_cnt = 1;
      end else if (dram_ras_n) hi_cnt++;
      else lo_cnt++;
      if (!dram_cas_n && prev_cas && dram_ras_n)
        chk(!req_ready, "R12 ready in refresh", 1, 0);
      if (!dram_cas_n && prev_cas && !dram_ras_n) begin
        chk(lo_cnt > B_RCD, "R3 ras to cas", lo_cnt - 1, B_RCD);
        cas_gap = cyc - last_cas_fall;
        last_cas_fall = cyc;
        if (!dram_we_n) begin
          chk(dram_dq_oe && dram_oe_n, "R9 write strobes", {30'd0, dram_dq_oe, dram_oe_n}, 3);
          mem[int'({m_row, dram_addr})] = dram_dq_out;
        end else begin
          chk(dram_dq_oe == 1'b0, "R9 no drive on read", 1, 0);
          dq_model = mem.exists(int'({m_row, dram_addr})) ? mem[int'({m_row, dram_addr})] : 8'h00;
        end
      end
      if (rsp_valid) begin
        rsp_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected response", rsp_rdata, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(rsp_rdata) == e, "R8 read data", rsp_rdata, e);
        end
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
    end
  end

  task automatic req(input bit we, input logic [17:0] a, input logic [7:0] d);
    int w;
    w = 0;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (1) begin
      #2;
      if (req_ready) break;
      w++;
      @(negedge clk);
    end
    if (w > max_wait) max_wait = w;
    if (we) sh[int'(a)] = d;
    else exp_q.push_back(int'(sh[int'(a)]));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int f0, r0, n0;
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset", 0, 1);
    chk(!dram_dq_oe && !rsp_valid, "R1 outputs in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes after reset", 0, 1);
    chk(req_ready && !rsp_valid && !dram_dq_oe, "R1 ready after reset", 0, 1);

    f0 = ras_falls;
    for (int i = 0; i < 8; i++) req(1'b1, {9'd3, 9'(i)}, 8'(8'h40 + i * 7));
    idle(1);
    chk(ras_falls - f0 == 1, "R6 one activation for write burst", ras_falls - f0, 1);
    chk(cas_gap == B_PAGE, "R6 page spacing writes", cas_gap, B_PAGE);
    chk(rsp_cnt == 0, "R9 no response for writes", rsp_cnt, 0);
    f0 = ras_falls;
    for (int i = 7; i >= 0; i--) req(1'b0, {9'd3, 9'(i)}, 8'h00);
    idle(6);
    chk(ras_falls == f0, "R6 no ras edge on hits", ras_falls - f0, 0);
    chk(cas_gap == B_PAGE, "R6 page spacing reads", cas_gap, B_PAGE);
    chk(exp_q.size() == 0 && rsp_cnt == 8, "R8 all reads answered", rsp_cnt, 8);

    f0 = ras_falls; r0 = ras_rises;
    req(1'b1, {9'h0AA, 9'h155}, 8'hA5);
    req(1'b1, {9'h155, 9'h155}, 8'h5A);
    req(1'b0, {9'h0AA, 9'h155}, 8'h00);
    req(1'b0, {9'h155, 9'h155}, 8'h00);
    idle(8);
    chk(ras_falls - f0 == 4, "R7 activation per miss", ras_falls - f0, 4);
    chk(ras_rises - r0 == 4, "R7 precharge per miss", ras_rises - r0, 4);
    chk(m_row == 9'h155, "R2 row on bus at ras fall", m_row, 9'h155);
    chk(mem.exists(int'({9'h0AA, 9'h155})) && mem[int'({9'h0AA, 9'h155})] == 8'hA5,
        "R2 distinct row storage", 0, 8'hA5);
    chk(exp_q.size() == 0, "R8 miss reads answered", exp_q.size(), 0);

    r0 = ras_rises;
    idle(B_RASMAX + 60);
    chk(dram_ras_n == 1'b1, "R5 idle row closed", 0, 1);
    chk(ras_rises - r0 == 1, "R5 one close", ras_rises - r0, 1);

    for (int i = 0; i < 4; i++) req(1'b1, {9'd5, 9'(i)}, 8'(8'h90 + i));
    while (cyc < B_REFI - 40) @(negedge clk);
    n0 = refreshes;
    max_wait = 0;
    for (int i = 0; i < 40; i++) req(1'b0, {9'd5, 9'(i % 4)}, 8'h00);
    idle(10);
    chk(refreshes == n0 + 1, "R11 refresh inside stream", refreshes - n0, 1);
    chk(max_wait >= B_PRE, "R11 request held by refresh", max_wait, B_PRE);
    chk(exp_q.size() == 0, "R11 stream reads all served", exp_q.size(), 0);

    while (cyc < 4 * B_REFI + 60) begin
      req(1'b0, {9'd3, 9'd2}, 8'h00);
      idle(97);
    end
    chk(refreshes >= 4, "R10 refresh count", refreshes, 4);
    chk(exp_q.size() == 0, "R8 final drain", exp_q.size(), 0);
    finish_run();
  end
endmodule